// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block generates the raster timing for a display output path. From software-programmed active sizes, sync widths and porches, it produces horizontal sync, vertical sync, data-enable and blanking signals. It also forwards a pixel stream to the output. During active video the pixel is passed through, and its red and blue components can be exchanged. Outside active video the pixel output is zero.

Software programs the block over a simple 32-bit register bus. Writes are single-cycle and reads are combinational. Four events can each raise a maskable interrupt: frame start, the first active pixel of a frame, a missing input pixel during active video, and the start of a programmed line. Timing values written while the raster runs are held in shadow form. The counters pick them up only at the next frame boundary, so a frame is never split between two configurations.

Top module: `vid_timing_gen`

## Requirements
- R1: After reset the register reads are as follows. Enable (0x00), soft reset (0x04), interrupt enable (0x08), status (0x0C), output setting (0x14) and target line (0xF0) read 0. Timing reads a 640x480 active area with horizontal sync/back/front 24/12/4 and vertical sync/back/front 2/33/10. The sync and data-enable outputs are low and blanking is high.
- R2: Timing runs only while bit 0 of 0x00 is 1. While it is 0, hsync, vsync and data-enable stay low. In the first cycle after it is set, the raster is at pixel 0 of line 0.
- R3: A line is sync, back porch, active and front porch, in that order, each lasting exactly its programmed number of clock cycles. hsync is high during the sync part.
- R4: A frame is sync, back porch, active and front porch lines, in that order, each lasting exactly its programmed number of lines. vsync is high during the sync lines. Data-enable is high only where the horizontal and vertical active parts meet.
- R5: The blanking output is the inverse of data-enable.
- R6: Register 0x18 holds the vertical active size in [31:16] and the horizontal active size in [15:0]. 0x20 and 0x28 hold the horizontal and vertical sync widths in [15:0]. 0x24 and 0x2C hold the front porch in [31:16] and the back porch in [15:0]. All of them read back as written.
- R7: Timing values written while running take effect at the next frame start. The frame in progress keeps its old timing.
- R8: While bit 0 of 0x04 is 1, the counters stay at the frame origin, the sync and data-enable outputs stay low, and the status is held at 0. Clearing the bit restarts the raster at pixel 0 of line 0.
- R9: Status bits at 0x0C are: bit 0 frame start, bit 1 first active pixel of a frame, bit 2 underflow, bit 3 pixel 0 of the target line (0xF0). Each bit sets in the cycle after its event, whatever the interrupt enable holds.
- R10: Writing 0 to a status bit clears it. Writing 1 leaves it unchanged. An event in the same cycle wins over a clear.
- R11: irqOut is high exactly when some status bit and the interrupt-enable bit at the same position (0x08) are both 1.
- R12: When pixValid is low in an active cycle, status bit 2 sets and the pixel output is zero in that cycle.
- R13: In active cycles with pixValid high, pixOut equals pixIn, with red in [23:16], green in [15:8] and blue in [7:0]. When bit 0 of 0x14 is 1, the red and blue components are exchanged. Outside active cycles pixOut is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register byte address |
| busWr | input | 1 | Write strobe, one register per cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pixIn | input | 24 | Incoming pixel |
| pixValid | input | 1 | Incoming pixel present |
| pixOut | output | 24 | Outgoing pixel |
| hsyncOut | output | 1 | Horizontal sync, active high |
| vsyncOut | output | 1 | Vertical sync, active high |
| deOut | output | 1 | Data enable |
| blankOut | output | 1 | Blanking |
| irqOut | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a timing write that lands in the middle of a running frame. The shadow rule is only visible if the frame in progress keeps its old active width while the next frame takes the new one. The bench therefore waits until the raster is partway through a frame, writes a different horizontal size, and keeps comparing every cycle against a cycle-accurate model across the frame boundary. The model latches its own timing copy only at frame wrap. A second hard case is the exact cycle in which a status bit appears. The bench reads the status one cycle before and one cycle after the start of the target line.

// File: rtl/vtg_pkg.sv
`timescale 1ns/1ps
package vtg_pkg;
  localparam int unsigned FIELD_W = 16;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned NUM_IRQ = 4;

  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_SRST   = 8'h04;
  localparam logic [ADDR_W-1:0] ADDR_INTEN  = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 8'h0C;
  localparam logic [ADDR_W-1:0] ADDR_OUTSET = 8'h14;
  localparam logic [ADDR_W-1:0] ADDR_SIZE   = 8'h18;
  localparam logic [ADDR_W-1:0] ADDR_HSYNC  = 8'h20;
  localparam logic [ADDR_W-1:0] ADDR_HPORCH = 8'h24;
  localparam logic [ADDR_W-1:0] ADDR_VSYNC  = 8'h28;
  localparam logic [ADDR_W-1:0] ADDR_VPORCH = 8'h2C;
  localparam logic [ADDR_W-1:0] ADDR_TARGET = 8'hF0;

  typedef logic [FIELD_W-1:0] fld_t;

  typedef struct packed {
    fld_t sync;
    fld_t back;
    fld_t act;
    fld_t front;
  } axis_t;

  typedef struct packed {
    axis_t h;
    axis_t v;
  } timing_t;

  // control -> datapath
  typedef struct packed {
    logic    run;
    logic    rbSwap;
    fld_t    targetLine;
    timing_t timing;
  } ctl_t;

  // datapath -> control, bit order equals the status bit order
  typedef struct packed {
    logic targetHit;
    logic underflow;
    logic activeStart;
    logic frameStart;
  } evt_t;

  localparam timing_t DEFAULT_TIMING = '{
    h: '{sync: 16'd24, back: 16'd12, act: 16'd640, front: 16'd4},
    v: '{sync: 16'd2,  back: 16'd33, act: 16'd480, front: 16'd10}
  };
endpackage

// File: rtl/vtg_axis.sv
`timescale 1ns/1ps
module vtg_axis
  import vtg_pkg::*;
#(
  parameter int unsigned POS_W = FIELD_W + 2
) (
  input  logic [POS_W-1:0] pos,
  input  axis_t            cfg,
  output logic             inSync,
  output logic             inActive,
  output logic             isFirstActive,
  output logic             isLast
);
  localparam int unsigned PAD = POS_W - FIELD_W;

  logic [POS_W-1:0] syncEnd;
  logic [POS_W-1:0] actBegin;
  logic [POS_W-1:0] actEnd;
  logic [POS_W-1:0] total;

  always_comb begin
    syncEnd  = {{PAD{1'b0}}, cfg.sync};
    actBegin = syncEnd + {{PAD{1'b0}}, cfg.back};
    actEnd   = actBegin + {{PAD{1'b0}}, cfg.act};
    total    = actEnd + {{PAD{1'b0}}, cfg.front};
  end

  assign inSync        = pos < syncEnd;
  assign inActive      = (pos >= actBegin) && (pos < actEnd);
  assign isFirstActive = (pos == actBegin) && (cfg.act != '0);
  assign isLast        = (pos + POS_W'(1)) >= total;
endmodule

// File: rtl/vtg_path.sv
`timescale 1ns/1ps
module vtg_path
  import vtg_pkg::*;
#(
  parameter  int unsigned COMP_W = 8,
  localparam int unsigned PIX_W  = 3 * COMP_W,
  localparam int unsigned POS_W  = FIELD_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_t             ctl,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             pixValid,
  output logic [PIX_W-1:0] pixOut,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             deOut,
  output logic             blankOut,
  output evt_t             evt
);
  logic [POS_W-1:0] hPos;
  logic [POS_W-1:0] vPos;
  timing_t          live;

  logic hSync, hAct, hFirst, hLast;
  logic vSync, vAct, vFirst, vLast;

  vtg_axis #(.POS_W(POS_W)) hAxis_i (
    .pos(hPos), .cfg(live.h),
    .inSync(hSync), .inActive(hAct), .isFirstActive(hFirst), .isLast(hLast)
  );

  vtg_axis #(.POS_W(POS_W)) vAxis_i (
    .pos(vPos), .cfg(live.v),
    .inSync(vSync), .inActive(vAct), .isFirstActive(vFirst), .isLast(vLast)
  );

  // raster counters; the live timing copy is refreshed only at frame wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPos <= '0;
      vPos <= '0;
      live <= DEFAULT_TIMING;
    end else if (!ctl.run) begin
      hPos <= '0;
      vPos <= '0;
      live <= ctl.timing;
    end else if (hLast) begin
      hPos <= '0;
      if (vLast) begin
        vPos <= '0;
        live <= ctl.timing;
      end else begin
        vPos <= vPos + POS_W'(1);
      end
    end else begin
      hPos <= hPos + POS_W'(1);
    end
  end

  logic activeNow;
  logic atOrigin;
  assign activeNow = ctl.run && hAct && vAct;
  assign atOrigin  = (hPos == '0) && (vPos == '0);

  assign hsyncOut = ctl.run && hSync;
  assign vsyncOut = ctl.run && vSync;
  assign deOut    = activeNow;
  assign blankOut = !activeNow;

  // component exchange: outer components trade places, middle stays
  logic [PIX_W-1:0] swapped;
  for (genvar c = 0; c < 3; c++) begin : g_swap
    assign swapped[c*COMP_W +: COMP_W] = pixIn[(2-c)*COMP_W +: COMP_W];
  end

  always_comb begin
    if (activeNow && pixValid) pixOut = ctl.rbSwap ? swapped : pixIn;
    else                       pixOut = '0;
  end

  always_comb begin
    evt.frameStart  = ctl.run && atOrigin;
    evt.activeStart = ctl.run && hFirst && vFirst;
    evt.underflow   = activeNow && !pixValid;
    evt.targetHit   = ctl.run && (hPos == '0) &&
                      (vPos == {{(POS_W-FIELD_W){1'b0}}, ctl.targetLine});
  end

  AST_DE_NOT_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    deOut |-> (!hsyncOut && !vsyncOut)); // R3

  AST_IDLE_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> (hPos == '0 && vPos == '0)); // R8

  AST_SHADOW_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && !(hLast && vLast)) |=> $stable(live)); // R7

  AST_UFLOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (deOut && !pixValid) |-> (pixOut == '0)); // R12

  AST_BLANK_INV: assert property (@(posedge clk) disable iff (!rstN)
    $countones({deOut, blankOut}) == 1); // R5
endmodule

// File: rtl/vtg_ctrl.sv
`timescale 1ns/1ps
module vtg_ctrl
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  evt_t              evt,
  output ctl_t              ctl,
  output logic              irqOut
);
  logic               enReg;
  logic               rstReg;
  logic               swapReg;
  logic [NUM_IRQ-1:0] intEn;
  logic [NUM_IRQ-1:0] sta;
  logic [NUM_IRQ-1:0] evtVec;
  fld_t               target;
  timing_t            prog;

  logic wrHit [ADDR_TARGET+1];
  for (genvar a = 0; a <= ADDR_TARGET; a++) begin : g_dec
    assign wrHit[a] = busWr && (busAddr == ADDR_W'(a));
  end

  assign evtVec = evt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      rstReg  <= 1'b0;
      swapReg <= 1'b0;
      intEn   <= '0;
      target  <= '0;
      prog    <= DEFAULT_TIMING;
    end else begin
      if (wrHit[ADDR_ENABLE]) enReg   <= busWdata[0];
      if (wrHit[ADDR_SRST])   rstReg  <= busWdata[0];
      if (wrHit[ADDR_OUTSET]) swapReg <= busWdata[0];
      if (wrHit[ADDR_INTEN])  intEn   <= busWdata[NUM_IRQ-1:0];
      if (wrHit[ADDR_TARGET]) target  <= busWdata[FIELD_W-1:0];
      if (wrHit[ADDR_SIZE]) begin
        prog.v.act <= busWdata[DATA_W-1:FIELD_W];
        prog.h.act <= busWdata[FIELD_W-1:0];
      end
      if (wrHit[ADDR_HSYNC]) prog.h.sync <= busWdata[FIELD_W-1:0];
      if (wrHit[ADDR_HPORCH]) begin
        prog.h.front <= busWdata[DATA_W-1:FIELD_W];
        prog.h.back  <= busWdata[FIELD_W-1:0];
      end
      if (wrHit[ADDR_VSYNC]) prog.v.sync <= busWdata[FIELD_W-1:0];
      if (wrHit[ADDR_VPORCH]) begin
        prog.v.front <= busWdata[DATA_W-1:FIELD_W];
        prog.v.back  <= busWdata[FIELD_W-1:0];
      end
    end
  end

  // status: write-zero clears, events set and win over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       sta <= '0;
    else if (rstReg) sta <= '0;
    else sta <= (wrHit[ADDR_STATUS] ? (sta & busWdata[NUM_IRQ-1:0]) : sta) | evtVec;
  end

  assign irqOut = |(sta & intEn);

  always_comb begin
    ctl.run        = enReg && !rstReg;
    ctl.rbSwap     = swapReg;
    ctl.targetLine = target;
    ctl.timing     = prog;
  end

  always_comb begin
    unique case (busAddr)
      ADDR_ENABLE: busRdata = DATA_W'(enReg);
      ADDR_SRST:   busRdata = DATA_W'(rstReg);
      ADDR_INTEN:  busRdata = DATA_W'(intEn);
      ADDR_STATUS: busRdata = DATA_W'(sta);
      ADDR_OUTSET: busRdata = DATA_W'(swapReg);
      ADDR_SIZE:   busRdata = {prog.v.act, prog.h.act};
      ADDR_HSYNC:  busRdata = DATA_W'(prog.h.sync);
      ADDR_HPORCH: busRdata = {prog.h.front, prog.h.back};
      ADDR_VSYNC:  busRdata = DATA_W'(prog.v.sync);
      ADDR_VPORCH: busRdata = {prog.v.front, prog.v.back};
      ADDR_TARGET: busRdata = DATA_W'(target);
      default:     busRdata = '0;
    endcase
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_staChk
    AST_STA_SET: assert property (@(posedge clk) disable iff (!rstN)
      (evtVec[i] && !rstReg) |=> sta[i]); // R9

    AST_STA_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (sta[i] && !rstReg && !(wrHit[ADDR_STATUS] && !busWdata[i])) |=> sta[i]); // R10
  end

  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    rstReg |=> (sta == '0)); // R8

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (intEn != '0)); // R11
endmodule

// File: rtl/vid_timing_gen.sv
`timescale 1ns/1ps
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter  int unsigned COMP_W = 8,
  localparam int unsigned PIX_W  = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PIX_W-1:0]  pixIn,
  input  logic              pixValid,
  output logic [PIX_W-1:0]  pixOut,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              deOut,
  output logic              blankOut,
  output logic              irqOut
);
  ctl_t ctl;
  evt_t evt;

  vtg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata),
    .evt(evt), .ctl(ctl), .irqOut(irqOut)
  );

  vtg_path #(.COMP_W(COMP_W)) path_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .pixIn(pixIn), .pixValid(pixValid), .pixOut(pixOut),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut), .blankOut(blankOut),
    .evt(evt)
  );
endmodule

// File: tb/vid_timing_gen_tb_top.sv
`timescale 1ns/1ps
module vid_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [23:0] pixIn = '0;
  logic        pixValid = 1'b1;
  logic [23:0] pixOut;
  logic        hsyncOut, vsyncOut, deOut, blankOut, irqOut;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  vid_timing_gen dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .pixIn(pixIn), .pixValid(pixValid), .pixOut(pixOut),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut), .blankOut(blankOut),
    .irqOut(irqOut)
  );

  // model: programmed timing, per-frame copy, raster position
  int pHs = 24, pHb = 12, pHa = 640, pHf = 4, pVs = 2, pVb = 33, pVa = 480, pVf = 10;
  int aHs, aHb, aHa, aHf, aVs, aVb, aVa, aVf;
  int mH = 0, mV = 0;
  bit running = 0;
  bit swapOn = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic loadShadow();
    aHs = pHs; aHb = pHb; aHa = pHa; aHf = pHf;
    aVs = pVs; aVb = pVb; aVa = pVa; aVf = pVf;
  endtask

  task automatic origin();
    mH = 0; mV = 0; loadShadow();
  endtask

  task automatic advance();
    if (running) begin
      if (mH == aHs + aHb + aHa + aHf - 1) begin
        mH = 0;
        if (mV == aVs + aVb + aVa + aVf - 1) begin
          mV = 0;
          loadShadow();
        end else mV++;
      end else mH++;
    end
  endtask

  function automatic bit modelDe();
    return running && (mH >= aHs + aHb) && (mH < aHs + aHb + aHa) &&
           (mV >= aVs + aVb) && (mV < aVs + aVb + aVa);
  endfunction

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0;
    advance();
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic step(int n, string req);
    for (int i = 0; i < n; i++) begin
      logic eHs, eVs, eDe;
      logic [23:0] ePix;
      pixIn = {8'(mH), 8'h5A, 8'(mV)} ^ 24'(i * 37);
      #1;
      eHs = running && (mH < aHs);
      eVs = running && (mV < aVs);
      eDe = modelDe();
      check(req, "hs/vs/de/blank", {28'd0, hsyncOut, vsyncOut, deOut, blankOut},
            {28'd0, eHs, eVs, eDe, !eDe});
      if (eDe && pixValid) ePix = swapOn ? {pixIn[7:0], pixIn[15:8], pixIn[23:16]} : pixIn;
      else ePix = '0;
      check(req, "pixel", {8'd0, pixOut}, {8'd0, ePix});
      @(negedge clk);
      advance();
    end
  endtask

  task automatic tReset();
    logic [31:0] d;
    busRead(8'h00, d); check("R1", "enable", d, 0);
    busRead(8'h04, d); check("R1", "srst", d, 0);
    busRead(8'h08, d); check("R1", "inten", d, 0);
    busRead(8'h0C, d); check("R1", "status", d, 0);
    busRead(8'h14, d); check("R1", "outset", d, 0);
    busRead(8'hF0, d); check("R1", "target", d, 0);
    busRead(8'h18, d); check("R1 R6", "size", d, 32'h01E0_0280);
    busRead(8'h20, d); check("R1 R6", "hsync", d, 24);
    busRead(8'h24, d); check("R1 R6", "hporch", d, 32'h0004_000C);
    busRead(8'h28, d); check("R1 R6", "vsync", d, 2);
    busRead(8'h2C, d); check("R1 R6", "vporch", d, 32'h000A_0021);
    check("R1", "outputs", {28'd0, hsyncOut, vsyncOut, deOut, blankOut}, 32'h1);
    check("R1", "irq", irqOut, 0);
  endtask

  task automatic tProgramAndRun();
    logic [31:0] d;
    busWrite(8'h20, 2);               pHs = 2;
    busWrite(8'h24, (1 << 16) | 3);   pHf = 1; pHb = 3;
    busWrite(8'h18, (3 << 16) | 4);   pVa = 3; pHa = 4;
    busWrite(8'h28, 1);               pVs = 1;
    busWrite(8'h2C, (1 << 16) | 2);   pVf = 1; pVb = 2;
    busRead(8'h18, d); check("R6", "size readback", d, 32'h0003_0004);
    busRead(8'h2C, d); check("R6", "vporch readback", d, 32'h0001_0002);
    step(5, "R2 idle");
    busWrite(8'h00, 1); running = 1; origin();
    check("R2", "origin syncs", {30'd0, hsyncOut, vsyncOut}, 3);
    step(140, "R3 R4 R5 R13");
  endtask

  task automatic tStatusAndClear();
    logic [31:0] d;
    busRead(8'h0C, d); check("R9", "status after frames", d, 4'b1011);
    check("R11", "irq masked", irqOut, 0);
    busWrite(8'h00, 0); running = 0;
    busWrite(8'h0C, 32'hE);
    busRead(8'h0C, d); check("R10", "clear bit0 only", d, 4'b1010);
    busWrite(8'h0C, 32'h0);
    busRead(8'h0C, d); check("R10", "clear all", d, 0);
  endtask

  task automatic tIrq();
    busWrite(8'h08, 1);
    busWrite(8'h00, 1); running = 1; origin();
    check("R11", "irq before event", irqOut, 0);
    step(1, "R11");
    check("R11", "irq after frame start", irqOut, 1);
    busWrite(8'h08, 0);
    check("R11", "irq disabled", irqOut, 0);
  endtask

  task automatic tTarget();
    logic [31:0] d;
    busWrite(8'h00, 0); running = 0;
    busWrite(8'h0C, 0);
    busWrite(8'hF0, 4);
    busWrite(8'h00, 1); running = 1; origin();
    step(40, "R9");
    busRead(8'h0C, d); check("R9", "target not yet", d[3], 0);
    check("R9", "active start seen", d[1], 1);
    step(1, "R9");
    busRead(8'h0C, d); check("R9", "target line hit", d[3], 1);
  endtask

  task automatic tUnderflow();
    logic [31:0] d;
    busWrite(8'h0C, 32'hB);
    busRead(8'h0C, d); check("R12", "no underflow yet", d[2], 0);
    while (!modelDe()) step(1, "R12");
    pixValid = 1'b0;
    step(1, "R12");
    pixValid = 1'b1;
    busRead(8'h0C, d); check("R12", "underflow flagged", d[2], 1);
  endtask

  task automatic tSwap();
    logic [31:0] d;
    busWrite(8'h14, 1); swapOn = 1;
    busRead(8'h14, d); check("R13", "swap readback", d, 1);
    step(70, "R13");
    busWrite(8'h14, 0); swapOn = 0;
    step(20, "R13");
  endtask

  task automatic tShadow();
    while (mV != 2) step(1, "R7");
    busWrite(8'h18, (3 << 16) | 6); pHa = 6; pVa = 3;
    check("R7", "old width still live", aHa, 4);
    step(160, "R7");
  endtask

  task automatic tSoftReset();
    logic [31:0] d;
    busWrite(8'h04, 1); running = 0;
    step(5, "R8");
    busRead(8'h0C, d); check("R8", "status held clear", d, 0);
    busRead(8'h04, d); check("R8", "srst readback", d, 1);
    busWrite(8'h04, 0); running = 1; origin();
    check("R8", "restart at origin", {30'd0, hsyncOut, vsyncOut}, 3);
    step(75, "R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    loadShadow();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tProgramAndRun();
    tStatusAndClear();
    tIrq();
    tTarget();
    tUnderflow();
    tSwap();
    tShadow();
    tSoftReset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule